// File: doc/BRIEF.md
# XOR Phase-Frequency Discriminator

This block compares two edge streams, a reference and an oscillator, both sampled as synchronous signals in a fast system clock domain. It drives one output bit. When that bit is averaged by a loop filter it gives the correction for the oscillator.

Near lock the output is the exclusive-OR of the two conditioned inputs, so its duty cycle grows linearly with the phase offset. Away from lock, one input may produce two rising edges while the other produces none. In that case a frequency flag takes over and pins the output at the level that pulls the oscillator toward the reference. This also stops the loop from settling on a harmonic. The flag drops on the first rising edge of the other input, and the phase comparison then resumes.

Top module: `xor_pfd`

## Requirements
- R1: A synchronous active-high `rst` clears `out_level`, `freq_high`, `freq_low` and all edge history on the next clock edge.
- R2: With no flag active, `out_level` equals `ref_in XOR osc_in` as sampled two clock edges earlier. Each input is registered once, and `out_level` is registered.
- R3: A second rising edge on `ref_in` with no `osc_in` rising edge since the previous one sets `freq_low`, two edges after the input rise. While `freq_low` is 1, `out_level` is 1.
- R4: A second rising edge on `osc_in` with no `ref_in` rising edge since the previous one sets `freq_high`, with the same latency. While `freq_high` is 1, `out_level` is 0.
- R5: `freq_low` clears on the first `osc_in` rising edge, and `freq_high` clears on the first `ref_in` rising edge. Either flag stays set while further edges arrive on its own input.
- R6: Rising edges on both inputs in the same sample cycle count as alternation. They clear both flags and all pending edge counts.
- R7: `freq_high` and `freq_low` are never 1 together. `freq_low` wins if both would set on the same clock.
- R8: At equal frequencies, with the oscillator lagging by d clocks within half a period P, the duty of `out_level` is about 2d/P.
- R9: With the oscillator much slower than the reference, the mean of `out_level` is above 75%. With it much faster, the mean is below 25%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| ref_in | input | 1 | reference edge stream |
| osc_in | input | 1 | oscillator edge stream |
| out_level | output | 1 | registered discriminator output |
| freq_high | output | 1 | oscillator-too-fast flag |
| freq_low | output | 1 | oscillator-too-slow flag |

## Verification
A wrong edge history or a stuck pending count shows up as a flag that sets one edge too early or too late. It can also show up as a flag that fails to drop on the opposite edge. Because the outputs are registered, either fault reaches the ports two clocks after the input edge that exposes it. The bench compares all three outputs on every clock against a counting model, so such a fault is reported within a few input periods. It also checks the averaged duty against the bounds for equal, slow, fast and coincident edge streams.

// File: rtl/xor_pfd.sv
module xor_pfd (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic osc_in,
  output logic out_level,
  output logic freq_high,
  output logic freq_low
);

  logic ref_q, ref_p, osc_q, osc_p;
  logic ref_arm, osc_arm;
  logic ref_rise, osc_rise, both_rise;
  logic ref_arm_n, osc_arm_n;
  logic low_set, high_set, low_n, high_n, out_n;

  assign ref_rise  = ref_q & ~ref_p;
  assign osc_rise  = osc_q & ~osc_p;
  assign both_rise = ref_rise & osc_rise;

  assign ref_arm_n = both_rise ? 1'b0 : ref_rise ? 1'b1 : osc_rise ? 1'b0 : ref_arm;
  assign osc_arm_n = both_rise ? 1'b0 : osc_rise ? 1'b1 : ref_rise ? 1'b0 : osc_arm;

  assign low_set  = ref_rise & ~osc_rise & ref_arm;
  assign high_set = osc_rise & ~ref_rise & osc_arm;

  assign low_n  = low_set | (freq_low & ~osc_rise);
  assign high_n = ~low_n & (high_set | (freq_high & ~ref_rise));

  assign out_n = low_n ? 1'b1 : high_n ? 1'b0 : (ref_q ^ osc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= 1'b0;
      ref_p     <= 1'b0;
      osc_q     <= 1'b0;
      osc_p     <= 1'b0;
      ref_arm   <= 1'b0;
      osc_arm   <= 1'b0;
      freq_low  <= 1'b0;
      freq_high <= 1'b0;
      out_level <= 1'b0;
    end else begin
      ref_q     <= ref_in;
      ref_p     <= ref_q;
      osc_q     <= osc_in;
      osc_p     <= osc_q;
      ref_arm   <= ref_arm_n;
      osc_arm   <= osc_arm_n;
      freq_low  <= low_n;
      freq_high <= high_n;
      out_level <= out_n;
    end
  end

endmodule

// File: rtl/xor_pfd_chk.sv
module xor_pfd_chk (
  input logic clk,
  input logic rst,
  input logic out_level,
  input logic freq_high,
  input logic freq_low
);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(freq_high && freq_low));

  a_r3_low_holds_high: assert property (@(posedge clk) disable iff (rst)
    freq_low |-> out_level);

  a_r4_high_holds_low: assert property (@(posedge clk) disable iff (rst)
    freq_high |-> !out_level);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_level && !freq_high && !freq_low));

  a_r5_no_direct_swap: assert property (@(posedge clk) disable iff (rst)
    $rose(freq_high) |-> !$past(freq_low));

endmodule

bind xor_pfd xor_pfd_chk u_chk (.*);

// File: tb/tb_xor_pfd.sv
module tb_xor_pfd;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, ref_in = 1'b0, osc_in = 1'b0;
  logic out_level, freq_high, freq_low;

  always #(CLK_P/2) clk = ~clk;

  xor_pfd dut (.*);

  int n_chk = 0, n_fail = 0, t = 0;
  bit done = 0;
  int s_r1 = 0, s_r2 = 0, s_o1 = 0, s_o2 = 0, n_ref = 0, n_osc = 0;
  bit e_out = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0d", tag, act, exp, t);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      s_r1 = 0; s_r2 = 0; s_o1 = 0; s_o2 = 0; n_ref = 0; n_osc = 0; e_out = 0;
    end else begin
      bit rr, oo;
      rr = (s_r1 == 1) && (s_r2 == 0);
      oo = (s_o1 == 1) && (s_o2 == 0);
      if (rr && oo) begin n_ref = 0; n_osc = 0; end
      else if (rr) begin n_ref = (n_ref < 2) ? n_ref + 1 : 2; n_osc = 0; end
      else if (oo) begin n_osc = (n_osc < 2) ? n_osc + 1 : 2; n_ref = 0; end
      e_out = (n_ref >= 2) ? 1'b1 : (n_osc >= 2) ? 1'b0 : (s_r1 != s_o1);
      s_r2 = s_r1; s_r1 = int'(ref_in);
      s_o2 = s_o1; s_o1 = int'(osc_in);
    end
  endtask

  task automatic run(input int pr, input int po, input int lag, input int cyc,
                     output int ones, output bit saw_hi, output bit saw_lo);
    ones = 0; saw_hi = 0; saw_lo = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(out_level == e_out, "R2 R3 R4 R8 out_level", int'(out_level), int'(e_out));
      check(freq_low == (n_ref >= 2), "R3 R5 R6 freq_low", int'(freq_low), int'(n_ref >= 2));
      check(freq_high == (n_osc >= 2), "R4 R5 R6 freq_high", int'(freq_high), int'(n_osc >= 2));
      check(!(freq_low && freq_high), "R7 exclusive", 1, 0);
      ones += int'(out_level);
      saw_hi |= freq_high;
      saw_lo |= freq_low;
      t++;
      ref_in = (t % pr) < pr / 2;
      osc_in = ((t + po * 1000 - lag) % po) < po / 2;
    end
  endtask

  initial begin
    int ones;
    bit hi, lo;
    rst = 1'b1;
    run(10, 10, 0, 3, ones, hi, lo);
    check(!out_level && !freq_high && !freq_low, "R1 reset state",
          int'({out_level, freq_high, freq_low}), 0);
    rst = 1'b0;

    run(20, 20, 5, 400, ones, hi, lo);
    check(ones >= 180 && ones <= 220, "R8 duty at lag P/4", ones, 200);
    check(!hi && !lo, "R5 no flag at equal rate", int'({hi, lo}), 0);

    run(10, 40, 0, 400, ones, hi, lo);
    check(lo && !hi, "R3 slow osc sets freq_low", int'({hi, lo}), 1);
    check(ones > 300, "R9 slow osc mean high", ones, 300);

    run(20, 20, 5, 200, ones, hi, lo);
    check(!freq_low && !freq_high, "R5 flags drop on alternation",
          int'({freq_high, freq_low}), 0);

    run(40, 10, 0, 400, ones, hi, lo);
    check(hi && !lo, "R4 fast osc sets freq_high", int'({hi, lo}), 2);
    check(ones < 100, "R9 fast osc mean low", ones, 100);

    rst = 1'b1;
    run(40, 10, 0, 1, ones, hi, lo);
    rst = 1'b0;
    check(!out_level && !freq_high && !freq_low, "R1 mid-run reset",
          int'({out_level, freq_high, freq_low}), 0);

    run(16, 16, 0, 400, ones, hi, lo);
    check(ones == 0, "R6 coincident edges give zero output", ones, 0);
    check(!hi && !lo, "R6 coincident edges set no flag", int'({hi, lo}), 0);

    run(20, 20, 2, 400, ones, hi, lo);
    check(ones >= 60 && ones <= 100, "R8 duty at lag 2 of 20", ones, 80);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", t, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule